// File: doc/BRIEF.md
# Return Address Stack

This block predicts where procedure returns will land. Every call event leaves its return address on a small circular stack. The block watches decoded loads whose destination is the program counter. When a load has the exact return shape, it pops the newest address and offers it as the predicted target. The shape is a post-indexed load from the stack pointer with an added immediate of four. Popping happens one cycle after the load is presented.

The branch unit later resolves the return. It reports the real target and whether the condition predictor guessed right. The block then reports the cycle cost of the return and its single memory cycle. The cost depends on which of the two predictions failed. Every resolution also takes a checkpoint of the stack position and depth. A pipeline flush rolls the stack back to that checkpoint, so speculative pushes and pops made after the last resolved branch are undone.

Top module: `ret_addr_stack`

## Requirements
- R1: A load counts as a return only when all of these hold:
  - `ld_to_pc` is 1;
  - `ld_base` is 13;
  - `ld_post_index` is 1;
  - `ld_add` is 1;
  - `ld_imm` is 4.

  A return raises `is_return` one cycle later. Any other field value gives `is_return` = 0 and leaves the stack unchanged.
- R2: `call_valid` pushes `call_ret_addr`. The stack keeps at most 4 entries. A push onto a full stack overwrites the oldest entry, so the 4 most recent addresses survive.
- R3: A recognised return on a non-empty stack pops the newest entry, in last-in first-out order. One cycle later it drives that entry on `pred_target` with `pred_valid` = 1.
- R4: A return on an empty stack leaves the stack unchanged and gives `pred_valid` = 0 and `pred_target` = 0. Its resolution counts as a return mispredict.
- R5: A resolution sets `cost_cycles` = 1 when both predictions were correct. That means the pending prediction was valid, it equals `res_target`, and `res_cond_miss` = 0.
- R6: A resolution sets `cost_cycles` = 9 whenever the return prediction was wrong or invalid, whatever the condition outcome.
- R7: A resolution sets `cost_cycles` = 8 when the return prediction was correct and `res_cond_miss` = 1.
- R8: Each resolution raises `cost_valid` one cycle later, with `mem_cycles` = 1. Without a resolution, `cost_valid` and `mem_cycles` are 0.
- R9: A call and a return in the same cycle act as a pop followed by a push. The prediction is the old newest entry, and the pushed address becomes the new newest entry.
- R10: A resolution outside a flush cycle records the current stack position and depth as the checkpoint. `flush` restores both from the checkpoint and ignores any call or load in that cycle. After reset the checkpoint is an empty stack.
- R11: After reset the stack is empty and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Roll the stack back to the last checkpoint |
| call_valid | input | 1 | A call retires a return address this cycle |
| call_ret_addr | input | ADDR_W | Return address to push |
| ld_valid | input | 1 | A decoded single load is presented |
| ld_to_pc | input | 1 | The load writes the program counter |
| ld_base | input | REG_W | Base register index |
| ld_post_index | input | 1 | Offset is applied after the access |
| ld_add | input | 1 | Offset is added (1) or subtracted (0) |
| ld_imm | input | IMM_W | Immediate offset |
| res_valid | input | 1 | Resolution of the pending return |
| res_target | input | ADDR_W | Actual target of the resolved return |
| res_cond_miss | input | 1 | The condition was predicted incorrectly |
| is_return | output | 1 | The load one cycle earlier was a recognised return |
| pred_valid | output | 1 | `pred_target` holds a popped address |
| pred_target | output | ADDR_W | Predicted return target |
| cost_valid | output | 1 | `cost_cycles` and `mem_cycles` are valid |
| cost_cycles | output | COST_W | Issue cycles of the resolved return |
| mem_cycles | output | 2 | Memory cycles of the resolved return |

## Verification
The checks assume that at most one return is outstanding. Each `res_valid` refers to the newest return recognised in an earlier cycle, and no resolution arrives in the same cycle as a new return. The stimulus keeps to this: it issues every return and waits for the prediction before it sends the matching resolution. It never combines a flush with a resolution. The reference model restates the stack as a wrapped integer pointer, a depth and a snapshot. The bench compares every output with that model on every clock, through overflow, empty pops, same-cycle call and return, and rollback.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Outcome of a resolved return, ordered by cost severity
  typedef enum logic [1:0] {
    OUT_HIT       = 2'd0,
    OUT_COND_MISS = 2'd1,
    OUT_RET_MISS  = 2'd2
  } outcome_e;

  // A wrong or missing return target dominates a condition miss
  function automatic outcome_e classify(input logic target_ok, input logic cond_ok);
    if (!target_ok) return OUT_RET_MISS;
    if (!cond_ok)   return OUT_COND_MISS;
    return OUT_HIT;
  endfunction

endpackage

// File: rtl/ras_decode.sv
module ras_decode #(
  parameter int REG_W   = 4,
  parameter int IMM_W   = 12,
  parameter int SP_IDX  = 13,
  parameter int RET_IMM = 4
) (
  input  logic             ld_to_pc,
  input  logic [REG_W-1:0] ld_base,
  input  logic             ld_post_index,
  input  logic             ld_add,
  input  logic [IMM_W-1:0] ld_imm,
  output logic             ret_form
);

  // Only a post-indexed pop of the stack pointer into the PC is a return
  function automatic logic is_ret_shape(
    input logic             to_pc,
    input logic [REG_W-1:0] base,
    input logic             post,
    input logic             add,
    input logic [IMM_W-1:0] imm
  );
    return to_pc && post && add &&
           (base == REG_W'(SP_IDX)) &&
           (imm == IMM_W'(RET_IMM));
  endfunction

  assign ret_form = is_ret_shape(ld_to_pc, ld_base, ld_post_index, ld_add, ld_imm);

endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push_en,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop_req,
  input  logic              ck_take,
  output logic              pop_hit,
  output logic [ADDR_W-1:0] pop_data,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  ck_cnt
);

  localparam logic [CNT_W-1:0] FULL   = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] P_ONE  = PTR_W'(1);
  localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] ent_q [DEPTH];
  logic [PTR_W-1:0]  top_q, top_mid, top_d, ck_top_q;
  logic [CNT_W-1:0]  cnt_q, cnt_mid, cnt_d, ck_cnt_q;
  logic              wr_en;

  assign pop_hit  = pop_req && (cnt_q != '0);
  assign pop_data = ent_q[top_q];
  assign wr_en    = push_en && !flush;

  // Pop first, then push; a flush overrides both
  always_comb begin
    top_mid = top_q;
    cnt_mid = cnt_q;
    if (pop_hit) begin
      top_mid = top_q - P_ONE;
      cnt_mid = cnt_q - C_ONE;
    end
    top_d = top_mid;
    cnt_d = cnt_mid;
    if (wr_en) begin
      top_d = top_mid + P_ONE;
      if (cnt_mid != FULL) cnt_d = cnt_mid + C_ONE;
    end
    if (flush) begin
      top_d = ck_top_q;
      cnt_d = ck_cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (wr_en) begin
      ent_q[top_d] <= push_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      cnt_q <= '0;
    end else begin
      top_q <= top_d;
      cnt_q <= cnt_d;
    end
  end

  // Checkpoint holds the position before this cycle's updates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_top_q <= '0;
      ck_cnt_q <= '0;
    end else if (ck_take && !flush) begin
      ck_top_q <= top_q;
      ck_cnt_q <= cnt_q;
    end
  end

  assign cnt    = cnt_q;
  assign ck_cnt = ck_cnt_q;

endmodule

// File: rtl/ras_cost.sv
module ras_cost #(
  parameter int ADDR_W        = 32,
  parameter int COST_W        = 4,
  parameter int CYC_HIT       = 1,
  parameter int CYC_COND_MISS = 8,
  parameter int CYC_RET_MISS  = 9,
  parameter int MEM_CYC       = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_fire,
  input  logic              ret_hit,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_target,
  input  logic              res_cond_miss,
  output logic              target_ok,
  output logic              cost_valid,
  output logic [COST_W-1:0] cost_cycles,
  output logic [1:0]        mem_cycles
);
  import ras_pkg::*;

  logic              pend_valid_q;
  logic [ADDR_W-1:0] pend_addr_q;
  outcome_e          outcome;
  logic [COST_W-1:0] cost_d;

  assign target_ok = pend_valid_q && (pend_addr_q == res_target);
  assign outcome   = classify(target_ok, !res_cond_miss);

  always_comb begin
    unique case (outcome)
      OUT_HIT:       cost_d = COST_W'(CYC_HIT);
      OUT_COND_MISS: cost_d = COST_W'(CYC_COND_MISS);
      default:       cost_d = COST_W'(CYC_RET_MISS);
    endcase
  end

  // Prediction of the newest recognised return, kept until the next one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid_q <= 1'b0;
      pend_addr_q  <= '0;
    end else if (ret_fire) begin
      pend_valid_q <= ret_hit;
      pend_addr_q  <= ret_hit ? ret_addr : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cost_valid  <= 1'b0;
      cost_cycles <= '0;
      mem_cycles  <= '0;
    end else begin
      cost_valid  <= res_valid;
      cost_cycles <= res_valid ? cost_d : '0;
      mem_cycles  <= res_valid ? 2'(MEM_CYC) : 2'd0;
    end
  end

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int ADDR_W        = 32,
  parameter int DEPTH         = 4,
  parameter int REG_W         = 4,
  parameter int IMM_W         = 12,
  parameter int SP_IDX        = 13,
  parameter int RET_IMM       = 4,
  parameter int COST_W        = 4,
  parameter int CYC_HIT       = 1,
  parameter int CYC_COND_MISS = 8,
  parameter int CYC_RET_MISS  = 9,
  parameter int MEM_CYC       = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              call_valid,
  input  logic [ADDR_W-1:0] call_ret_addr,
  input  logic              ld_valid,
  input  logic              ld_to_pc,
  input  logic [REG_W-1:0]  ld_base,
  input  logic              ld_post_index,
  input  logic              ld_add,
  input  logic [IMM_W-1:0]  ld_imm,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_target,
  input  logic              res_cond_miss,
  output logic              is_return,
  output logic              pred_valid,
  output logic [ADDR_W-1:0] pred_target,
  output logic              cost_valid,
  output logic [COST_W-1:0] cost_cycles,
  output logic [1:0]        mem_cycles
);

  // DEPTH is expected to be a power of two so the pointer wraps naturally
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  // Named internal events, also observed by the bound checker
  logic              ret_form;
  logic              pop_req;
  logic              push_en;
  logic              pop_hit;
  logic [ADDR_W-1:0] pop_data;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  ck_cnt;
  logic              target_ok;

  ras_decode #(
    .REG_W  (REG_W),
    .IMM_W  (IMM_W),
    .SP_IDX (SP_IDX),
    .RET_IMM(RET_IMM)
  ) u_decode (
    .ld_to_pc     (ld_to_pc),
    .ld_base      (ld_base),
    .ld_post_index(ld_post_index),
    .ld_add       (ld_add),
    .ld_imm       (ld_imm),
    .ret_form     (ret_form)
  );

  assign pop_req = ld_valid && ret_form && !flush;
  assign push_en = call_valid && !flush;

  ras_store #(
    .ADDR_W(ADDR_W),
    .DEPTH (DEPTH),
    .PTR_W (PTR_W),
    .CNT_W (CNT_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push_en  (push_en),
    .push_addr(call_ret_addr),
    .pop_req  (pop_req),
    .ck_take  (res_valid),
    .pop_hit  (pop_hit),
    .pop_data (pop_data),
    .cnt      (cnt),
    .ck_cnt   (ck_cnt)
  );

  ras_cost #(
    .ADDR_W       (ADDR_W),
    .COST_W       (COST_W),
    .CYC_HIT      (CYC_HIT),
    .CYC_COND_MISS(CYC_COND_MISS),
    .CYC_RET_MISS (CYC_RET_MISS),
    .MEM_CYC      (MEM_CYC)
  ) u_cost (
    .clk          (clk),
    .rst_n        (rst_n),
    .ret_fire     (pop_req),
    .ret_hit      (pop_hit),
    .ret_addr     (pop_data),
    .res_valid    (res_valid),
    .res_target   (res_target),
    .res_cond_miss(res_cond_miss),
    .target_ok    (target_ok),
    .cost_valid   (cost_valid),
    .cost_cycles  (cost_cycles),
    .mem_cycles   (mem_cycles)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_return   <= 1'b0;
      pred_valid  <= 1'b0;
      pred_target <= '0;
    end else begin
      is_return   <= pop_req;
      pred_valid  <= pop_hit;
      pred_target <= pop_hit ? pop_data : '0;
    end
  end

endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
  parameter int ADDR_W        = 32,
  parameter int DEPTH         = 4,
  parameter int CNT_W         = 3,
  parameter int COST_W        = 4,
  parameter int CYC_HIT       = 1,
  parameter int CYC_COND_MISS = 8,
  parameter int CYC_RET_MISS  = 9,
  parameter int MEM_CYC       = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              ld_valid,
  input logic              res_valid,
  input logic              push_en,
  input logic              pop_req,
  input logic              pop_hit,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  ck_cnt,
  input logic              is_return,
  input logic              pred_valid,
  input logic [ADDR_W-1:0] pred_target,
  input logic              cost_valid,
  input logic [COST_W-1:0] cost_cycles,
  input logic [1:0]        mem_cycles
);

  p_depth_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  p_full_push_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !pop_hit && cnt == CNT_W'(DEPTH)) |=> cnt == CNT_W'(DEPTH));

  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !pop_req && cnt != CNT_W'(DEPTH)) |=> cnt == $past(cnt) + CNT_W'(1));

  p_nonload_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !is_return);

  p_pop_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt != '0) |=> (pred_valid && is_return));

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt == '0) |=> (!pred_valid && pred_target == '0));

  p_invalid_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |-> pred_target == '0);

  p_cost_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cost_valid |-> (cost_cycles == COST_W'(CYC_HIT) ||
                    cost_cycles == COST_W'(CYC_COND_MISS) ||
                    cost_cycles == COST_W'(CYC_RET_MISS)));

  p_cost_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (cost_valid && mem_cycles == 2'(MEM_CYC)));

  p_cost_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> (!cost_valid && mem_cycles == 2'd0));

  p_flush_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt == $past(ck_cnt));

endmodule

bind ret_addr_stack ras_chk #(
  .ADDR_W       (ADDR_W),
  .DEPTH        (DEPTH),
  .CNT_W        (CNT_W),
  .COST_W       (COST_W),
  .CYC_HIT      (CYC_HIT),
  .CYC_COND_MISS(CYC_COND_MISS),
  .CYC_RET_MISS (CYC_RET_MISS),
  .MEM_CYC      (MEM_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .ld_valid   (ld_valid),
  .res_valid  (res_valid),
  .push_en    (push_en),
  .pop_req    (pop_req),
  .pop_hit    (pop_hit),
  .cnt        (cnt),
  .ck_cnt     (ck_cnt),
  .is_return  (is_return),
  .pred_valid (pred_valid),
  .pred_target(pred_target),
  .cost_valid (cost_valid),
  .cost_cycles(cost_cycles),
  .mem_cycles (mem_cycles)
);

// File: tb/sim_ret_addr_stack.sv
module sim_ret_addr_stack;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush, call_valid, ld_valid, ld_to_pc, ld_post_index, ld_add;
  logic        res_valid, res_cond_miss;
  logic [31:0] call_ret_addr, res_target;
  logic [3:0]  ld_base;
  logic [11:0] ld_imm;
  logic        is_return, pred_valid, cost_valid;
  logic [31:0] pred_target;
  logic [3:0]  cost_cycles;
  logic [1:0]  mem_cycles;

  always #5 clk = ~clk;

  ret_addr_stack u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .call_valid(call_valid), .call_ret_addr(call_ret_addr),
    .ld_valid(ld_valid), .ld_to_pc(ld_to_pc), .ld_base(ld_base),
    .ld_post_index(ld_post_index), .ld_add(ld_add), .ld_imm(ld_imm),
    .res_valid(res_valid), .res_target(res_target), .res_cond_miss(res_cond_miss),
    .is_return(is_return), .pred_valid(pred_valid), .pred_target(pred_target),
    .cost_valid(cost_valid), .cost_cycles(cost_cycles), .mem_cycles(mem_cycles)
  );

  // Reference model: ring of 4 addressed by an unbounded integer cursor
  logic [31:0] ring [4];
  integer      cur, depth, snap_cur, snap_depth;
  logic        pend_ok;
  logic [31:0] pend_addr;
  logic        e_ret, e_pv, e_cv;
  logic [31:0] e_pt;
  integer      e_cost, e_mem;

  integer vectors = 0, miscompares = 0, cycles = 0;
  string  cur_req = "R11";
  bit     done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur = 0; depth = 0; snap_cur = 0; snap_depth = 0;
      pend_ok = 0; pend_addr = 0;
      e_ret = 0; e_pv = 0; e_pt = 0; e_cv = 0; e_cost = 0; e_mem = 0;
    end else begin
      automatic bit shape = ld_to_pc && ld_base == 4'd13 && ld_post_index
                            && ld_add && ld_imm == 12'd4;
      automatic bit r = ld_valid && shape && !flush;
      e_cv = res_valid; e_mem = res_valid ? 1 : 0; e_cost = 0;
      if (res_valid) begin
        if (!(pend_ok && pend_addr == res_target)) e_cost = 9;
        else if (res_cond_miss)                    e_cost = 8;
        else                                       e_cost = 1;
        if (!flush) begin snap_cur = cur; snap_depth = depth; end
      end
      e_ret = r; e_pv = 0; e_pt = 0;
      if (flush) begin
        cur = snap_cur; depth = snap_depth;
      end else begin
        if (r) begin
          if (depth > 0) begin
            e_pv = 1; e_pt = ring[cur & 3]; cur = cur - 1; depth = depth - 1;
          end
          pend_ok = e_pv; pend_addr = e_pt;
        end
        if (call_valid) begin
          cur = cur + 1; ring[cur & 3] = call_ret_addr;
          if (depth < 4) depth = depth + 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (!done) begin
      vectors++;
      if (is_return !== e_ret || pred_valid !== e_pv || pred_target !== e_pt ||
          cost_valid !== e_cv || cost_cycles !== 4'(e_cost) || mem_cycles !== 2'(e_mem)) begin
        miscompares++;
        $display("FAIL %s: ret %0b/%0b pv %0b/%0b pt %h/%h cv %0b/%0b cost %0d/%0d mem %0d/%0d",
                 cur_req, is_return, e_ret, pred_valid, e_pv, pred_target, e_pt,
                 cost_valid, e_cv, cost_cycles, e_cost, mem_cycles, e_mem);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic clr();
    flush = 0; call_valid = 0; call_ret_addr = 0; ld_valid = 0; ld_to_pc = 0;
    ld_base = 0; ld_post_index = 0; ld_add = 0; ld_imm = 0;
    res_valid = 0; res_target = 0; res_cond_miss = 0;
  endtask

  task automatic set_ld(input logic pc, input logic [3:0] b, input logic post,
                        input logic add, input logic [11:0] imm);
    ld_valid = 1; ld_to_pc = pc; ld_base = b; ld_post_index = post; ld_add = add; ld_imm = imm;
  endtask

  task automatic push(input logic [31:0] a);
    call_valid = 1; call_ret_addr = a; @(negedge clk); clr();
  endtask

  task automatic load(input logic pc, input logic [3:0] b, input logic post,
                      input logic add, input logic [11:0] imm);
    set_ld(pc, b, post, add, imm); @(negedge clk); clr();
  endtask

  task automatic ret();
    load(1'b1, 4'd13, 1'b1, 1'b1, 12'd4);
  endtask

  task automatic resolve(input logic [31:0] t, input logic cm);
    res_valid = 1; res_target = t; res_cond_miss = cm; @(negedge clk); clr();
  endtask

  initial begin
    clr();
    rst_n = 0;
    // R11: reset state compared every cycle while held and just after
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    cur_req = "R2"; push(32'h1000_0100); push(32'h1000_0200); push(32'h1000_0300);
    cur_req = "R3"; ret();
    cur_req = "R5"; resolve(32'h1000_0300, 1'b0);
    cur_req = "R3"; ret(); cur_req = "R5"; resolve(32'h1000_0200, 1'b0);

    // R1: near-miss shapes must not pop
    cur_req = "R1";
    load(1, 13, 1, 1, 12'd8);
    load(1, 12, 1, 1, 12'd4);
    load(1, 13, 0, 1, 12'd4);
    load(1, 13, 1, 0, 12'd4);
    load(0, 13, 1, 1, 12'd4);
    ret(); resolve(32'h1000_0100, 1'b0);

    // R4: empty pop, resolution counts as return mispredict
    cur_req = "R4"; ret(); resolve(32'h1000_0100, 1'b0);

    // R2: overflow keeps the four newest
    cur_req = "R2";
    for (int i = 1; i <= 6; i++) push(32'h2000_0000 + 32'(i * 16));
    for (int i = 6; i >= 2; i--) begin
      cur_req = (i >= 3) ? "R3" : "R4";
      ret(); resolve(32'h2000_0000 + 32'(i * 16), 1'b0);
    end

    cur_req = "R6"; push(32'h3000_0010); ret(); resolve(32'h3000_0BAD, 1'b0);
    cur_req = "R7"; push(32'h3000_0020); ret(); resolve(32'h3000_0020, 1'b1);
    cur_req = "R6"; push(32'h3000_0030); ret(); resolve(32'h3000_0BAD, 1'b1);
    cur_req = "R8"; idle_chk();

    // R9: call and return in one cycle
    cur_req = "R9"; push(32'h4000_0010);
    call_valid = 1; call_ret_addr = 32'h4000_0020; set_ld(1, 13, 1, 1, 12'd4);
    @(negedge clk); clr();
    ret(); resolve(32'h4000_0020, 1'b0);
    ret();

    // R10: checkpoint then rollback, flush cycle ignores call and load
    cur_req = "R10";
    push(32'h5000_0010); push(32'h5000_0020);
    resolve(32'h5000_0020, 1'b0);
    push(32'h5000_0030); ret(); ret(); ret();
    flush = 1; call_valid = 1; call_ret_addr = 32'h5000_0FFF; set_ld(1, 13, 1, 1, 12'd4);
    @(negedge clk); clr();
    ret(); ret(); ret();
    repeat (3) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic idle_chk();
    repeat (2) @(negedge clk);
  endtask

endmodule